// File: doc/BRIEF.md
# Trigger Output Selector with Hold

This block drives a single trigger output pin from one of five trigger sources: a software flag, the level seen on the incoming trigger pin, the level of the outgoing pin's own path, the converter's internal trigger and the logic analyser's trigger. A 3-bit code picks the source. Code zero, the reset and default choice, and any code above five disable the output and hold it inactive.

A change of the chosen level reaches the pin one clock edge later. Every change of the pin then starts a hold window. For the length of that window the pin keeps its new level, whatever the source does. When the window ends, the pin takes the source's level at that moment. If that level differs from the pin, the pin changes at once and a new window starts. A short glitch on a source therefore becomes a clean pulse at least one hold period wide. Switching the select code counts as a source change and obeys the same hold.

The hold length is a 20-bit cycle count and is sampled at the moment the pin changes. At a 100 MHz clock this allows up to about 10 ms, and a typical setting of 200000 cycles gives 2 ms.

Top module: `trig_out_hold`

## Requirements
- R1: After reset the pin is 0 and no hold is pending, so the first source change passes after one edge.
- R2: Select code 1 picks the software flag, 2 the input-pin trigger, 3 the output-pin trigger, 4 the internal converter trigger and 5 the logic-analyser trigger. Codes 0, 6 and 7 drive the pin to 0 whatever the sources do.
- R3: With no hold pending, a change of the selected level appears on the pin after exactly one rising clock edge.
- R4: Two pin changes are never closer than max(P,1) clock cycles, where P is the hold count in force at the first of the two changes. P = 0 gives a spacing of one cycle.
- R5: When a hold ends and the selected level differs from the pin, the pin changes on the first edge allowed and a new hold starts. If the level equals the pin, the pin keeps its level.
- R6: A source pulse shorter than P cycles shows on the pin as a pulse exactly P cycles wide.
- R7: A change of the select code that changes the selected level is treated as a source change and obeys the hold.
- R8: The hold count is taken when the pin changes. Writing a new count during a hold leaves the current hold as it is and applies from the next change.
- R9: The full 20-bit hold count, 0xFFFFF, is honoured: the pin stays held after thousands of cycles.
- R10: An active-low asynchronous reset clears the pin and cancels any hold at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 3 | Source select code (see R2) |
| sw_trig | input | 1 | Software trigger flag |
| pin_trig_in | input | 1 | Trigger level from the input pin path |
| pin_trig_out | input | 1 | Trigger level from the output pin path |
| adc_trig | input | 1 | Internal converter trigger |
| la_trig | input | 1 | Logic-analyser trigger |
| hold_cycles | input | 20 | Hold length in clock cycles |
| trig_pin | output | 1 | Registered trigger pin level |

## Verification
The bench builds the block with its default parameters: five sources, a 3-bit select and a 20-bit hold counter. Hold counts of 0, 3, 4, 5, 6, 8 and 9 keep each hold window short enough to measure in full. This exposes the zero-count case, windows that re-arm one after another, and a hold count written in the middle of a window. A count of 0xFFFFF tests the full counter width, and an asynchronous reset ends that hold early.

// File: rtl/trig_hold_pkg.sv
package trig_hold_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 5;
    localparam int HOLD_W  = 20;

    // Select codes; the code value minus one is the source vector index.
    typedef enum logic [SEL_W-1:0] {
        SEL_OFF      = 3'd0,
        SEL_SW       = 3'd1,
        SEL_PIN_IN   = 3'd2,
        SEL_PIN_OUT  = 3'd3,
        SEL_ADC      = 3'd4,
        SEL_LA       = 3'd5
    } trig_sel_e;
endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
    parameter int NUM_SRC = 5,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src_vec,
    output logic               level
);
    logic [NUM_SRC-1:0] hit;

    // Code 0 and any code past NUM_SRC match no lane, so the level is 0.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        assign hit[i] = (sel == SEL_W'(i + 1)) & src_vec[i];
    end

    assign level = |hit;
endmodule

// File: rtl/trig_hold_timer.sv
module trig_hold_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] period,
    output logic             open
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = period;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // A count of one still lets the next edge change the pin, so two
    // changes are exactly `period` cycles apart.
    assign open = (tmr_q.cnt <= CNT_W'(1));
endmodule

// File: rtl/trig_out_hold.sv
module trig_out_hold
    import trig_hold_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic              sw_trig,
    input  logic              pin_trig_in,
    input  logic              pin_trig_out,
    input  logic              adc_trig,
    input  logic              la_trig,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              trig_pin
);
    typedef struct packed {
        logic pin;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_SRC-1:0] src_vec;
    logic               src_level;
    logic               hold_open;
    logic               take;

    // Lane order follows the select codes: lane i is code i+1.
    assign src_vec = {la_trig, adc_trig, pin_trig_out, pin_trig_in, sw_trig};

    trig_src_mux #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_mux (
        .sel     (src_sel),
        .src_vec (src_vec),
        .level   (src_level)
    );

    trig_hold_timer #(
        .CNT_W  (HOLD_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take),
        .period (hold_cycles),
        .open   (hold_open)
    );

    always_comb begin
        out_d = out_q;
        take  = hold_open && (src_level != out_q.pin);
        if (take) begin
            out_d.pin = src_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign trig_pin = out_q.pin;
endmodule

// File: rtl/trig_out_hold_chk.sv
module trig_out_hold_chk
    import trig_hold_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  src_sel,
    input logic [HOLD_W-1:0] hold_cycles,
    input logic              src_level,
    input logic              hold_open,
    input logic              trig_pin
);
    logic              prev_pin;
    logic [HOLD_W:0]   since;
    logic [HOLD_W-1:0] hold_prev;
    logic [HOLD_W-1:0] need;
    logic [HOLD_W:0]   need_min;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_pin  <= 1'b0;
            since     <= '1;
            hold_prev <= '0;
            need      <= '0;
        end else begin
            prev_pin  <= trig_pin;
            hold_prev <= hold_cycles;
            if (trig_pin != prev_pin) begin
                since <= (HOLD_W+1)'(1);
                need  <= hold_prev;
            end else if (since != '1) begin
                since <= since + (HOLD_W+1)'(1);
            end
        end
    end

    assign need_min = (need == '0) ? (HOLD_W+1)'(1) : {1'b0, need};

    // R2: disabled and unused codes give an inactive selected level
    p_off_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd0 || src_sel > 3'd5) |-> !src_level);

    // R3 and R5: when the hold allows it, the pin follows the source on the next edge
    p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_open |=> (trig_pin == $past(src_level)));

    // R4: inside a hold the pin does not move
    p_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_open |=> $stable(trig_pin));

    // R4: changes of the pin are at least the programmed spacing apart
    p_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pin != prev_pin) |-> (since >= need_min));
endmodule

bind trig_out_hold trig_out_hold_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel     (src_sel),
    .hold_cycles (hold_cycles),
    .src_level   (src_level),
    .hold_open   (hold_open),
    .trig_pin    (trig_pin)
);

// File: tb/trig_out_hold_bench.sv
module trig_out_hold_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  src_sel;
    logic        sw_trig, pin_trig_in, pin_trig_out, adc_trig, la_trig;
    logic [19:0] hold_cycles;
    logic        trig_pin;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    trig_out_hold u_trig_out_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_sel      (src_sel),
        .sw_trig      (sw_trig),
        .pin_trig_in  (pin_trig_in),
        .pin_trig_out (pin_trig_out),
        .adc_trig     (adc_trig),
        .la_trig      (la_trig),
        .hold_cycles  (hold_cycles),
        .trig_pin     (trig_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_srcs();
        sw_trig = 0; pin_trig_in = 0; pin_trig_out = 0; adc_trig = 0; la_trig = 0;
    endtask

    task automatic do_reset();
        clear_srcs();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    // Counts negedges on which the pin holds lvl, starting with the current one.
    task automatic measure(input logic lvl, output int w);
        w = 0;
        while (trig_pin == lvl && w < 3000) begin
            w++;
            step();
        end
    endtask

    task automatic t_reset();
        src_sel = 3'd0; hold_cycles = 20'd7;
        do_reset();
        chk("R1 pin after reset", trig_pin, 0);
        src_sel = 3'd1; sw_trig = 1;
        step();
        chk("R1 no pending hold after reset", trig_pin, 1);
    endtask

    task automatic t_sources();
        hold_cycles = 20'd0;
        for (int code = 1; code <= 5; code++) begin
            do_reset();
            src_sel = 3'(code);
            case (code)
                1: sw_trig = 1;
                2: pin_trig_in = 1;
                3: pin_trig_out = 1;
                4: adc_trig = 1;
                default: la_trig = 1;
            endcase
            chk("R3 no change before edge", trig_pin, 0);
            step();
            chk("R2 R3 selected source rises", trig_pin, 1);
            clear_srcs();
            step();
            chk("R2 R3 selected source falls", trig_pin, 0);
        end
        for (int code = 0; code <= 7; code++) begin
            if (code == 0 || code >= 6) begin
                do_reset();
                src_sel = 3'(code);
                sw_trig = 1; pin_trig_in = 1; pin_trig_out = 1; adc_trig = 1; la_trig = 1;
                step(); chk("R2 disabled code", trig_pin, 0);
                step(); step();
                chk("R2 disabled code stays low", trig_pin, 0);
            end
        end
    endtask

    task automatic t_short_pulse();
        int w;
        do_reset();
        src_sel = 3'd1; hold_cycles = 20'd6;
        sw_trig = 1; step();
        chk("R3 pulse start", trig_pin, 1);
        sw_trig = 0;
        measure(1'b1, w);
        chk("R6 one-cycle pulse stretched", w, 6);
        step(); step();
        chk("R6 low after stretch", trig_pin, 0);

        do_reset();
        hold_cycles = 20'd9;
        sw_trig = 1; step(); step();
        sw_trig = 0;
        measure(1'b1, w);
        chk("R6 two-cycle pulse stretched", w, 8);

        do_reset();
        hold_cycles = 20'd0;
        sw_trig = 1; step();
        sw_trig = 0;
        measure(1'b1, w);
        chk("R4 zero count spacing", w, 1);
    endtask

    task automatic t_rearm();
        int w;
        do_reset();
        src_sel = 3'd1; hold_cycles = 20'd5;
        sw_trig = 1; step();
        sw_trig = 0; step();
        sw_trig = 1;
        repeat (10) step();
        chk("R5 level equal at expiry keeps pin", trig_pin, 1);

        do_reset();
        sw_trig = 1; step();
        sw_trig = 0;
        measure(1'b1, w);
        chk("R4 first hold width", w, 5);
        sw_trig = 1;
        measure(1'b0, w);
        chk("R5 second transition held", w, 5);
        chk("R5 pin follows after second hold", trig_pin, 1);
    endtask

    task automatic t_sel();
        int w;
        do_reset();
        hold_cycles = 20'd4;
        src_sel = 3'd1; sw_trig = 1; adc_trig = 0;
        step();
        chk("R7 start high", trig_pin, 1);
        src_sel = 3'd4;
        measure(1'b1, w);
        chk("R7 select change held", w, 4);
    endtask

    task automatic t_period();
        int w;
        do_reset();
        src_sel = 3'd1; hold_cycles = 20'd3;
        sw_trig = 1; step();
        hold_cycles = 20'd8;
        sw_trig = 0;
        measure(1'b1, w);
        chk("R8 current hold unchanged", w, 3);
        sw_trig = 1;
        measure(1'b0, w);
        chk("R8 new count applies next", w, 8);
    endtask

    task automatic t_max();
        do_reset();
        src_sel = 3'd1; hold_cycles = 20'hFFFFF;
        sw_trig = 1; step();
        sw_trig = 0;
        repeat (2000) step();
        chk("R9 full count still holding", trig_pin, 1);
        rst_n = 1'b0;
        #1;
        chk("R10 async reset clears pin", trig_pin, 0);
        step();
        rst_n = 1'b1;
        step();
        sw_trig = 1; step();
        chk("R10 hold cancelled by reset", trig_pin, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        src_sel = 3'd0;
        hold_cycles = 20'd0;
        clear_srcs();
        t_reset();
        t_sources();
        t_short_pulse();
        t_rearm();
        t_sel();
        t_period();
        t_max();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule